// File: doc/BRIEF.md
# Protection and Burst Supervisor for a Switching Controller

This block is a synchronous supervisor that sits beside the PWM path of a current-mode switching controller. It receives comparator results that have already been digitised and produces a single gate-enable. The inputs are supply over-voltage, supply below the reset level, under-voltage lockout, protection pin over threshold, line under-voltage, overload sense and the two burst comparators. It also receives the switching clock and an off-time strobe.

Faults fall into two classes, and each has its own way out. Latching faults are a supply over-voltage that lasts long enough, or a protection pin trip. They hold the gate off until the supply falls below the reset level. Auto-restart faults are an overload or a line under-voltage that lasts for the persistence window. They raise a restart request, which forces a lockout cycle and is cleared only by that lockout. A short line under-voltage blocks the gate only while it is present.

Light-load operation uses burst gating. After a set number of consecutive off-time samples above the entry level, the gate is held off until an off-time sample falls below the exit level. All time windows are counted in ticks of a system-clock prescaler.

Top module: `psup_top`

## Requirements
- R1: Out of reset with all flags low, gate_en is 1 and fault_latched and restart_req are 0.
- R2: A high latch_pin_flag sets fault_latched on the next clock edge, and gate_en is 0 while fault_latched is 1.
- R3: ovp_flag must stay high for OVP_TICKS prescaler ticks before fault_latched sets. A pulse shorter than (OVP_TICKS-1)*PRESC_DIV clocks leaves no fault. A level held for OVP_TICKS*PRESC_DIV+2 clocks sets it.
- R4: fault_latched clears only on a clock edge where vcc_rst_flag is 1. uvlo_flag has no effect on it.
- R5: olp_flag is sampled only on edges where sw_clk is 1. If it stays asserted for PERSIST_TICKS ticks, restart_req sets and gate_en goes to 0.
- R6: A low olp_flag sampled while sw_clk is 1 restarts the overload window from zero. Lows that are seen only while sw_clk is 0 are ignored.
- R7: restart_req stays set until an edge where uvlo_flag is 1, and it clears on that edge.
- R8: gate_en is 0 in the same cycle that line_uv_flag is 1, without waiting for a clock edge.
- R9: A line under-voltage shorter than (PERSIST_TICKS-1)*PRESC_DIV clocks lets gate_en return to 1 with no restart_req. One held for PERSIST_TICKS*PRESC_DIV+2 clocks sets restart_req.
- R10: Burst gating (gate_en 0) begins on the BURST_CYCLES-th consecutive off_strobe that sees burst_on_flag at 1. A strobe that sees it at 0 resets the run. Flag changes without a strobe do nothing.
- R11: While gating, an off_strobe that sees burst_off_flag at 1 ends gating. burst_off_flag without a strobe has no effect.
- R12: uvlo_flag at 1 forces gate_en to 0 and ends burst gating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovp_flag | input | 1 | Supply above the over-voltage level |
| vcc_rst_flag | input | 1 | Supply below the latch-reset level |
| uvlo_flag | input | 1 | Under-voltage lockout active |
| latch_pin_flag | input | 1 | Protection pin above its trip level |
| line_uv_flag | input | 1 | Line voltage below its minimum |
| olp_flag | input | 1 | Feedback offset below the overload level |
| burst_on_flag | input | 1 | Burst sense above the entry level |
| burst_off_flag | input | 1 | Burst sense below the exit level |
| sw_clk | input | 1 | Switching clock, high phase qualifies the overload sample |
| off_strobe | input | 1 | One-cycle pulse per switching cycle during off-time |
| gate_en | output | 1 | Permission for the gate driver |
| fault_latched | output | 1 | A latching fault is held |
| restart_req | output | 1 | Request for a forced lockout restart |

## Verification
The timers are tested with two kinds of stimulus. One is a flag held just below the minimum window and one just above the maximum window, which separates a correct persistence count from a missing or off-by-tick counter. The overload sense gets two interrupted patterns. In one the dips land in the switching clock's high phase, and in the other only in its low phase, so a timer that ignores the qualification is caught either way. The burst stimulus mixes broken runs of entry strobes, flags without strobes, and an exit while gating, which tells a consecutive-count filter from a plain total. Each fault class is also offered the other class's clearing input, to show that the two reset paths stay separate.

// File: rtl/psup_pkg.sv
package psup_pkg;

  // counter width able to hold values 0..lim
  function automatic int unsigned cnt_w(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

  // gate permission: no blocker may be active
  function automatic logic gate_allow(input logic [5:0] blockers);
    return ~|blockers;
  endfunction

endpackage

// File: rtl/psup_tick.sv
module psup_tick #(
  parameter int unsigned PRESC_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int unsigned W = psup_pkg::cnt_w(PRESC_DIV - 1);
  localparam logic [W-1:0] LAST = W'(PRESC_DIV - 1);

  logic [W-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            div_q <= '0;
    else if (div_q == LAST) div_q <= '0;
    else                   div_q <= div_q + 1'b1;
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/psup_persist.sv
module psup_persist #(
  parameter int unsigned LIMIT = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sample_en,
  input  logic cond,
  input  logic clr,
  output logic expire,
  output logic fault
);
  localparam int unsigned W = psup_pkg::cnt_w(LIMIT);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic         armed_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         armed_q <= 1'b0;
    else if (clr)       armed_q <= 1'b0;
    else if (sample_en) armed_q <= cond;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cnt_q <= '0;
    else if (clr)                        cnt_q <= '0;
    else if (sample_en && !cond)         cnt_q <= '0;
    else if (armed_q && tick && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign expire = (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fault <= 1'b0;
    else if (clr)    fault <= 1'b0;
    else if (expire) fault <= 1'b1;
  end
endmodule

// File: rtl/psup_burst.sv
module psup_burst #(
  parameter int unsigned BURST_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic strobe,
  input  logic enter_hi,
  input  logic exit_lo,
  output logic enter_evt,
  output logic active
);
  localparam int unsigned W = psup_pkg::cnt_w(BURST_CYCLES);
  localparam logic [W-1:0] LAST = W'(BURST_CYCLES - 1);

  logic [W-1:0] run_q;

  assign enter_evt = strobe && !active && enter_hi && (run_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      active <= 1'b0;
    end else if (clr) begin
      run_q  <= '0;
      active <= 1'b0;
    end else if (strobe) begin
      if (!active) begin
        if (enter_evt) begin
          active <= 1'b1;
          run_q  <= '0;
        end else if (enter_hi) begin
          run_q <= run_q + 1'b1;
        end else begin
          run_q <= '0;
        end
      end else if (exit_lo) begin
        active <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/psup_top.sv
module psup_top #(
  parameter int unsigned PRESC_DIV     = 8,
  parameter int unsigned OVP_TICKS     = 4,
  parameter int unsigned PERSIST_TICKS = 40,
  parameter int unsigned BURST_CYCLES  = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovp_flag,
  input  logic vcc_rst_flag,
  input  logic uvlo_flag,
  input  logic latch_pin_flag,
  input  logic line_uv_flag,
  input  logic olp_flag,
  input  logic burst_on_flag,
  input  logic burst_off_flag,
  input  logic sw_clk,
  input  logic off_strobe,
  output logic gate_en,
  output logic fault_latched,
  output logic restart_req
);
  logic tick;
  logic ovp_expire, ovp_fault;
  logic olp_expire, olp_fault;
  logic luv_expire, luv_fault;
  logic burst_evt, burst_on;
  logic pin_trip_q;

  psup_tick #(.PRESC_DIV(PRESC_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  // supply over-voltage: persistence then latch, cleared by the reset-level flag
  psup_persist #(.LIMIT(OVP_TICKS)) u_ovp (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sample_en(1'b1), .cond(ovp_flag), .clr(vcc_rst_flag),
    .expire(ovp_expire), .fault(ovp_fault)
  );

  // overload: sampled in the switching clock high phase, cleared by lockout
  psup_persist #(.LIMIT(PERSIST_TICKS)) u_olp (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sample_en(sw_clk), .cond(olp_flag), .clr(uvlo_flag),
    .expire(olp_expire), .fault(olp_fault)
  );

  // line under-voltage beyond the window, cleared by lockout
  psup_persist #(.LIMIT(PERSIST_TICKS)) u_luv (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sample_en(1'b1), .cond(line_uv_flag), .clr(uvlo_flag),
    .expire(luv_expire), .fault(luv_fault)
  );

  psup_burst #(.BURST_CYCLES(BURST_CYCLES)) u_burst (
    .clk(clk), .rst_n(rst_n), .clr(uvlo_flag), .strobe(off_strobe),
    .enter_hi(burst_on_flag), .exit_lo(burst_off_flag),
    .enter_evt(burst_evt), .active(burst_on)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             pin_trip_q <= 1'b0;
    else if (vcc_rst_flag)  pin_trip_q <= 1'b0;
    else if (latch_pin_flag) pin_trip_q <= 1'b1;
  end

  assign fault_latched = ovp_fault | pin_trip_q;
  assign restart_req   = olp_fault | luv_fault;
  assign gate_en = psup_pkg::gate_allow({fault_latched, olp_fault, luv_fault,
                                         burst_on, uvlo_flag, line_uv_flag});
endmodule

// File: rtl/psup_chk.sv
module psup_chk (
  input logic clk,
  input logic rst_n,
  input logic ovp_flag,
  input logic vcc_rst_flag,
  input logic uvlo_flag,
  input logic latch_pin_flag,
  input logic line_uv_flag,
  input logic off_strobe,
  input logic burst_on_flag,
  input logic gate_en,
  input logic fault_latched,
  input logic restart_req,
  input logic olp_expire,
  input logic luv_expire,
  input logic burst_on
);
  p_latch_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fault_latched |-> !gate_en);

  p_latch_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_latched) |-> $past(ovp_flag || latch_pin_flag));

  p_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_latched && !vcc_rst_flag) |=> fault_latched);

  p_restart_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_req) |-> $past(olp_expire || luv_expire));

  p_restart_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req && !uvlo_flag) |=> restart_req);

  p_luv_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    line_uv_flag |-> !gate_en);

  p_burst_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(burst_on) |-> $past(off_strobe && burst_on_flag));

  p_uvlo_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    uvlo_flag |-> !gate_en);
endmodule

bind psup_top psup_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ovp_flag(ovp_flag), .vcc_rst_flag(vcc_rst_flag),
  .uvlo_flag(uvlo_flag), .latch_pin_flag(latch_pin_flag),
  .line_uv_flag(line_uv_flag), .off_strobe(off_strobe),
  .burst_on_flag(burst_on_flag), .gate_en(gate_en),
  .fault_latched(fault_latched), .restart_req(restart_req),
  .olp_expire(olp_expire), .luv_expire(luv_expire), .burst_on(burst_on)
);

// File: tb/psup_top_bench.sv
module psup_top_bench;
  localparam int unsigned DIV = 8;
  localparam int unsigned OVPT = 4;
  localparam int unsigned PT = 40;
  localparam int unsigned BC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ovp_flag = 0, vcc_rst_flag = 0, uvlo_flag = 0, latch_pin_flag = 0;
  logic line_uv_flag = 0, olp_flag = 0, burst_on_flag = 0, burst_off_flag = 0;
  logic sw_clk = 0, off_strobe = 0;
  logic gate_en, fault_latched, restart_req;

  int total = 0;
  int fails = 0;
  int cyc = 0;
  int sw_ph = 0;

  always #4 clk = ~clk;

  psup_top #(.PRESC_DIV(DIV), .OVP_TICKS(OVPT), .PERSIST_TICKS(PT),
             .BURST_CYCLES(BC)) u_psup_top (
    .clk(clk), .rst_n(rst_n), .ovp_flag(ovp_flag), .vcc_rst_flag(vcc_rst_flag),
    .uvlo_flag(uvlo_flag), .latch_pin_flag(latch_pin_flag),
    .line_uv_flag(line_uv_flag), .olp_flag(olp_flag),
    .burst_on_flag(burst_on_flag), .burst_off_flag(burst_off_flag),
    .sw_clk(sw_clk), .off_strobe(off_strobe), .gate_en(gate_en),
    .fault_latched(fault_latched), .restart_req(restart_req)
  );

  // switching clock: period 10 system clocks, changes between edges
  always @(posedge clk) begin
    #2;
    sw_ph  = (sw_ph == 9) ? 0 : sw_ph + 1;
    sw_clk = (sw_ph < 5);
  end

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic uvlo_pulse();
    uvlo_flag = 1'b1;
    cycles(1);
    uvlo_flag = 1'b0;
    cycles(1);
  endtask

  task automatic vrst_pulse();
    vcc_rst_flag = 1'b1;
    cycles(1);
    vcc_rst_flag = 1'b0;
    cycles(1);
  endtask

  task automatic t_reset();
    chk("R1 gate_en", gate_en, 1'b1);
    chk("R1 fault_latched", fault_latched, 1'b0);
    chk("R1 restart_req", restart_req, 1'b0);
  endtask

  task automatic t_latch_pin();
    latch_pin_flag = 1'b1;
    cycles(1);
    chk("R2 fault_latched", fault_latched, 1'b1);
    chk("R2 gate_en", gate_en, 1'b0);
    latch_pin_flag = 1'b0;
    cycles(3);
    chk("R4 held after pin drop", fault_latched, 1'b1);
    uvlo_pulse();
    chk("R4 uvlo no effect", fault_latched, 1'b1);
    vrst_pulse();
    chk("R4 cleared by reset level", fault_latched, 1'b0);
    chk("R4 gate back", gate_en, 1'b1);
  endtask

  task automatic t_ovp();
    ovp_flag = 1'b1;
    cycles((OVPT - 1) * DIV - 8);
    ovp_flag = 1'b0;
    cycles(2);
    chk("R3 short over-voltage", fault_latched, 1'b0);
    ovp_flag = 1'b1;
    cycles(OVPT * DIV + 8);
    chk("R3 long over-voltage", fault_latched, 1'b1);
    ovp_flag = 1'b0;
    cycles(2);
    vrst_pulse();
    chk("R4 ovp cleared", fault_latched, 1'b0);
  endtask

  task automatic t_luv();
    line_uv_flag = 1'b1;
    #1;
    chk("R8 same-cycle gate off", gate_en, 1'b0);
    cycles((PT - 1) * DIV - 32);
    line_uv_flag = 1'b0;
    cycles(1);
    chk("R9 short dip resumes", gate_en, 1'b1);
    chk("R9 short dip no restart", restart_req, 1'b0);
    line_uv_flag = 1'b1;
    cycles(PT * DIV + 20);
    chk("R9 long dip restart", restart_req, 1'b1);
    line_uv_flag = 1'b0;
    cycles(5);
    chk("R7 restart held", restart_req, 1'b1);
    chk("R7 gate held off", gate_en, 1'b0);
    uvlo_pulse();
    chk("R7 cleared by lockout", restart_req, 1'b0);
    chk("R7 gate back", gate_en, 1'b1);
  endtask

  task automatic t_olp();
    olp_flag = 1'b1;
    cycles(PT * DIV + 20);
    chk("R5 overload restart", restart_req, 1'b1);
    chk("R5 gate off", gate_en, 1'b0);
    olp_flag = 1'b0;
    cycles(5);
    vrst_pulse();
    chk("R7 reset level no effect", restart_req, 1'b1);
    uvlo_pulse();
    chk("R7 overload cleared", restart_req, 1'b0);
  endtask

  task automatic t_olp_break();
    olp_flag = 1'b1;
    cycles(200);
    olp_flag = 1'b0;
    cycles(12);
    olp_flag = 1'b1;
    cycles(200);
    chk("R6 high-phase break restarts window", restart_req, 1'b0);
    olp_flag = 1'b0;
    cycles(12);
  endtask

  task automatic t_olp_dip();
    olp_flag = 1'b1;
    for (int i = 0; i < 45; i++) begin
      do @(negedge clk); while (sw_clk !== 1'b1);
      do @(negedge clk); while (sw_clk !== 1'b0);
      olp_flag = 1'b0;
      cycles(2);
      olp_flag = 1'b1;
    end
    chk("R6 low-phase dips ignored", restart_req, 1'b1);
    olp_flag = 1'b0;
    cycles(12);
    uvlo_pulse();
  endtask

  task automatic strobe(input logic en_hi, input logic ex_lo);
    burst_on_flag  = en_hi;
    burst_off_flag = ex_lo;
    off_strobe     = 1'b1;
    cycles(1);
    off_strobe     = 1'b0;
    burst_on_flag  = 1'b0;
    burst_off_flag = 1'b0;
    cycles(2);
  endtask

  task automatic t_burst();
    for (int i = 0; i < BC - 1; i++) strobe(1'b1, 1'b0);
    strobe(1'b0, 1'b0);
    chk("R10 broken run", gate_en, 1'b1);
    burst_on_flag = 1'b1;
    cycles(5);
    burst_on_flag = 1'b0;
    cycles(1);
    chk("R10 flag without strobe", gate_en, 1'b1);
    for (int i = 0; i < BC - 1; i++) strobe(1'b1, 1'b0);
    chk("R10 one short of entry", gate_en, 1'b1);
    strobe(1'b1, 1'b0);
    chk("R10 entry", gate_en, 1'b0);
    burst_off_flag = 1'b1;
    cycles(4);
    burst_off_flag = 1'b0;
    cycles(1);
    chk("R11 exit flag without strobe", gate_en, 1'b0);
    strobe(1'b0, 1'b1);
    chk("R11 exit", gate_en, 1'b1);
    for (int i = 0; i < BC; i++) strobe(1'b1, 1'b0);
    chk("R12 burst re-entered", gate_en, 1'b0);
    uvlo_flag = 1'b1;
    cycles(1);
    chk("R12 gate off in lockout", gate_en, 1'b0);
    uvlo_flag = 1'b0;
    cycles(1);
    chk("R12 lockout ends burst", gate_en, 1'b1);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(2);
    t_reset();
    t_latch_pin();
    t_ovp();
    t_luv();
    t_olp();
    t_olp_break();
    t_olp_dip();
    t_burst();
    summary();
  end
endmodule